// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a clocked, synthesizable model of a byte-wide memory that can be programmed once and erased only in bulk. Three active-low strobes, two voltage-present flags and the address select the operating mode: read, output off, standby, program, program inhibit, verify or identifier readout. The data bus is split into a write-data input, a read-data output and a tri-state enable. A separate flag reports when the read data has settled.

A word leaves erase with every bit at 1. Programming can only clear bits: each write pulse ANDs the word on the data input into the addressed word. A high-voltage flag on address pin 9 swaps the array for a fixed two-byte identifier, chosen by address bit 0. The address access time is modelled as a parameter, `RD_LAT`, counted in clock cycles. A synchronous bulk-erase test input puts every word back to all ones.

The address port is 17 bits wide. The stored array is kept to `2**STORE_AW` words so that the model stays small. Address bits at or above `STORE_AW` take no part in array indexing, so the array repeats across the address space.

Top module: `otp_prom`

## Requirements
- R1: The array holds 2**STORE_AW bytes (default STORE_AW = 10, 1024 bytes). They are indexed by addr_i[STORE_AW-1:0], and higher address bits alias. After reset every byte reads 0xFF.
- R2: data_oe_o is 1 exactly when ce_ni = 0 and oe_ni = 0. With ce_ni = 1 both data_oe_o and data_valid_o are 0, whatever oe_ni is.
- R3: Normal read uses vpp_i = 0, ce_ni = 0, oe_ni = 0 and a9_hv_i = 0. data_valid_o first rises RD_LAT rising edges after a new address or mode is applied, and is 0 in between. While it is 1, data_o equals the stored byte. data_o is 0 whenever data_valid_o is 0.
- R4: Program mode uses vpp_i = 1, ce_ni = 0 and pgm_ni = 0. Exactly one write happens, at the first rising edge where pgm_ni is low after being high. That write stores old_byte & data_i at the address.
- R5: Programming never turns a 0 bit into 1. Writing 1s over already-cleared bits leaves them 0.
- R6: Verify mode uses vpp_i = 1, ce_ni = 0, oe_ni = 0 and pgm_ni = 1. It returns the stored byte with the same latency as R3.
- R7: Program inhibit uses vpp_i = 1 and ce_ni = 1. A pgm_ni pulse writes nothing, and data_oe_o stays 0.
- R8: Identifier mode uses vpp_i = 0, a9_hv_i = 1, ce_ni = 0, oe_ni = 0 and pgm_ni = 1. It returns 0x20 when addr_i[0] = 0 and 0x05 when addr_i[0] = 1, whatever the array holds. Every address bit other than 0 and 9 must be 0 in this mode.
- R9: erase_i high at a rising edge sets every byte to 0xFF. It takes priority over a write at the same edge.
- R10: With ce_ni = 0 and oe_ni = 1, and no program pulse, data_oe_o and data_valid_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Byte address |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| vpp_i | input | 1 | Programming voltage present |
| a9_hv_i | input | 1 | High voltage present on address pin 9 |
| erase_i | input | 1 | Synchronous bulk erase |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Read data, zero when not valid |
| data_oe_o | output | 1 | Tri-state enable for the data bus |
| data_valid_o | output | 1 | Read data settled |

## Verification
The main function is checked with reads of erased words, words after one program pulse, and words after a second pulse whose data holds 1s over bits already cleared. Together these show whether a write is an AND or a plain overwrite. An aliased address, a neighbouring unwritten address, and identifier reads after the same locations were cleared show whether indexing and the identifier path are independent of the array. Program pulses under inhibit and under a simultaneous erase show whether a mode that must not write still does. The scoreboard times every read, so a wrong settle latency shows up even when the data is right.

// File: rtl/otp_prom_pkg.sv
package otp_prom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_INHIBIT = 3'd1,
    MD_OUT_OFF = 3'd2,
    MD_READ    = 3'd3,
    MD_PROGRAM = 3'd4,
    MD_VERIFY  = 3'd5,
    MD_IDENT   = 3'd6
  } otp_mode_e;

  function automatic logic mode_reads(otp_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_prom_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output otp_mode_e         mode_o,
  output logic              wr_en_o
);

  localparam logic [ADDR_W-1:0] IdFreeMask = ADDR_W'(10'h201);

  logic pgm_q;

  always_comb begin
    if (ce_ni) begin
      mode_o = vpp_i ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_i) begin
      if (!pgm_ni)     mode_o = MD_PROGRAM;
      else if (!oe_ni) mode_o = MD_VERIFY;
      else             mode_o = MD_OUT_OFF;
    end else if (!oe_ni) begin
      mode_o = (a9_hv_i && pgm_ni) ? MD_IDENT : MD_READ;
    end else begin
      mode_o = MD_OUT_OFF;
    end
  end

  // strobe history: one write per falling edge of pgm_ni
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgm_q <= 1'b1;
    else         pgm_q <= pgm_ni;
  end

  assign wr_en_o = (mode_o == MD_PROGRAM) && pgm_q;

  p_single_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o)
    else $error("second write within one program pulse");

  p_id_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_IDENT) |-> ((addr_i & ~IdFreeMask) == '0))
    else $error("address bit other than 0 and 9 high in identifier mode");

  p_inhibit_nowrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !wr_en_o)
    else $error("write while chip deselected");

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int WORD_W = 8,
  parameter int AW     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     idx_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              erase_i,
  output logic [WORD_W-1:0] rd_word_o
);

  localparam int Depth = 1 << AW;

  logic [WORD_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[idx_i] <= mem_q[idx_i] & wdata_i;
    end
  end

  assign rd_word_o = mem_q[idx_i];

  p_clear_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_i |=> ((mem_q[$past(idx_i)] & ~$past(rd_word_o)) == '0))
    else $error("programming set a cleared bit");

  p_erase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (mem_q[$past(idx_i)] == '1))
    else $error("word not all ones after bulk erase");

endmodule

// File: rtl/otp_read_pipe.sv
module otp_read_pipe #(
  parameter int WORD_W = 8,
  parameter int KEY_W  = 20,
  parameter int RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_mode_i,
  input  logic              restart_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [WORD_W-1:0] fetch_i,
  output logic [WORD_W-1:0] data_o,
  output logic              vld_o
);

  localparam int              CntW   = $clog2(RD_LAT + 1);
  localparam logic [CntW-1:0] LatMax = CntW'(RD_LAT);

  logic [KEY_W-1:0] key_q;
  logic [CntW-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      cnt_q  <= '0;
      data_o <= '0;
    end else begin
      key_q  <= key_i;
      data_o <= fetch_i;
      if (!rd_mode_i || restart_i) cnt_q <= '0;
      else if (key_i != key_q)     cnt_q <= CntW'(1);
      else if (cnt_q < LatMax)     cnt_q <= cnt_q + CntW'(1);
    end
  end

  assign vld_o = (cnt_q == LatMax);

  p_valid_needs_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_mode_i |=> !vld_o)
    else $error("valid after a non-read cycle");

endmodule

// File: rtl/otp_prom.sv
module otp_prom
  import otp_prom_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          STORE_AW = 10,
  parameter int          WORD_W   = 8,
  parameter int          RD_LAT   = 2,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_i,
  input  logic              a9_hv_i,
  input  logic              erase_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              data_valid_o
);

  localparam int KeyW = ADDR_W + 3;

  otp_mode_e         mode;
  logic              wr_en;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] fetch;
  logic [WORD_W-1:0] pipe_data;
  logic              pipe_vld;
  logic [KeyW-1:0]   key;

  otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .pgm_ni  (pgm_ni),
    .vpp_i   (vpp_i),
    .a9_hv_i (a9_hv_i),
    .addr_i  (addr_i),
    .mode_o  (mode),
    .wr_en_o (wr_en)
  );

  otp_cell_array #(.WORD_W(WORD_W), .AW(STORE_AW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (addr_i[STORE_AW-1:0]),
    .wr_en_i   (wr_en),
    .wdata_i   (data_i),
    .erase_i   (erase_i),
    .rd_word_o (rd_word)
  );

  // identifier bytes bypass the array
  generate
    if (WORD_W == 8) begin : g_id8
      always_comb fetch = (mode == MD_IDENT) ? (addr_i[0] ? DEV_CODE : MFR_CODE) : rd_word;
    end else begin : g_idn
      always_comb fetch = (mode == MD_IDENT) ?
                          (addr_i[0] ? WORD_W'(DEV_CODE) : WORD_W'(MFR_CODE)) : rd_word;
    end
  endgenerate

  assign key = {mode, addr_i};

  otp_read_pipe #(.WORD_W(WORD_W), .KEY_W(KeyW), .RD_LAT(RD_LAT)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_mode_i (mode_reads(mode)),
    .restart_i (erase_i),
    .key_i     (key),
    .fetch_i   (fetch),
    .data_o    (pipe_data),
    .vld_o     (pipe_vld)
  );

  assign data_oe_o    = !ce_ni && !oe_ni;
  assign data_valid_o = data_oe_o && pipe_vld;
  assign data_o       = data_valid_o ? pipe_data : '0;

  p_standby_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_oe_o && !data_valid_o))
    else $error("bus driven in standby");

  p_out_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |-> !data_valid_o)
    else $error("valid with output enable inactive");

  p_zero_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> (data_o == '0))
    else $error("data nonzero while not valid");

endmodule

// File: tb/otp_prom_bench.sv
module otp_prom_bench;

  localparam int ADDR_W   = 17;
  localparam int STORE_AW = 10;
  localparam int RD_LAT   = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              ce_ni = 1'b1;
  logic              oe_ni = 1'b1;
  logic              pgm_ni = 1'b1;
  logic              vpp_i = 1'b0;
  logic              a9_hv_i = 1'b0;
  logic              erase_i = 1'b0;
  logic [7:0]        data_i = '0;
  logic [7:0]        data_o;
  logic              data_oe_o;
  logic              data_valid_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   age = 0;

  always #2 clk = ~clk;

  otp_prom #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW), .RD_LAT(RD_LAT)) u_otp_prom (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .ce_ni        (ce_ni),
    .oe_ni        (oe_ni),
    .pgm_ni       (pgm_ni),
    .vpp_i        (vpp_i),
    .a9_hv_i      (a9_hv_i),
    .erase_i      (erase_i),
    .data_i       (data_i),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o),
    .data_valid_o (data_valid_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per settled read, checks data and latency
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      age++;
      if (data_valid_o) begin
        chk(data_o == sb_q[0].d, {sb_q[0].tag, " data"}, data_o, sb_q[0].d);
        chk(age == RD_LAT, {sb_q[0].tag, " latency R3"}, age, RD_LAT);
        void'(sb_q.pop_front());
        age = 0;
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1; pgm_ni = 1'b1; vpp_i = 1'b0; a9_hv_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic vpp, input logic hv,
                    input logic [7:0] exp, input string tag);
    exp_t e;
    idle();
    @(negedge clk);
    addr_i = a; vpp_i = vpp; a9_hv_i = hv; pgm_ni = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0;
    e.d = exp; e.tag = tag;
    age = 0;
    sb_q.push_back(e);
    for (int i = 0; i < 32 && sb_q.size() > 0; i++) @(negedge clk);
    if (sb_q.size() > 0) begin
      chk(1'b0, {tag, " no valid read"}, 0, exp);
      sb_q.delete();
    end
    idle();
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input logic ce, input logic er);
    idle();
    @(negedge clk);
    addr_i = a; data_i = d; vpp_i = 1'b1; ce_ni = ce; oe_ni = 1'b1; pgm_ni = 1'b0; erase_i = er;
    @(negedge clk);
    pgm_ni = 1'b0; erase_i = 1'b0;
    @(negedge clk);
    pgm_ni = 1'b1;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data_oe_o == 1'b0, "R2 reset oe", data_oe_o, 0);
    chk(data_valid_o == 1'b0, "R2 reset valid", data_valid_o, 0);
    rst_ni = 1'b1;

    rd(17'd5, 1'b0, 1'b0, 8'hFF, "R1 erased read");
    prog(17'd5, 8'hA5, 1'b0, 1'b0);
    rd(17'd5, 1'b0, 1'b0, 8'hA5, "R4 programmed read");
    prog(17'd5, 8'hFF, 1'b0, 1'b0);
    rd(17'd5, 1'b0, 1'b0, 8'hA5, "R5 ones over zeros");
    prog(17'd5, 8'h0F, 1'b0, 1'b0);
    rd(17'd5, 1'b0, 1'b0, 8'h05, "R5 and-accumulate");
    rd(17'd5, 1'b1, 1'b0, 8'h05, "R6 verify read");
    rd(17'd5 + 17'(1 << STORE_AW), 1'b0, 1'b0, 8'h05, "R1 alias read");

    prog(17'd12, 8'h3C, 1'b0, 1'b0);
    rd(17'd12, 1'b0, 1'b0, 8'h3C, "R4 second word");
    rd(17'd13, 1'b0, 1'b0, 8'hFF, "R4 neighbour untouched");

    // program inhibit
    idle();
    @(negedge clk);
    addr_i = 17'd20; data_i = 8'h00; vpp_i = 1'b1; ce_ni = 1'b1; oe_ni = 1'b0; pgm_ni = 1'b0;
    @(negedge clk);
    chk(data_oe_o == 1'b0, "R7 inhibit hiz", data_oe_o, 0);
    pgm_ni = 1'b1;
    idle();
    rd(17'd20, 1'b0, 1'b0, 8'hFF, "R7 inhibit no write");

    // output disable and standby
    idle();
    @(negedge clk);
    addr_i = 17'd5; ce_ni = 1'b0; oe_ni = 1'b1;
    repeat (RD_LAT + 2) @(negedge clk);
    chk(data_oe_o == 1'b0, "R10 out off oe", data_oe_o, 0);
    chk(data_valid_o == 1'b0, "R10 out off valid", data_valid_o, 0);
    ce_ni = 1'b1; oe_ni = 1'b0;
    repeat (RD_LAT + 2) @(negedge clk);
    chk(data_oe_o == 1'b0, "R2 standby oe", data_oe_o, 0);
    chk(data_valid_o == 1'b0, "R2 standby valid", data_valid_o, 0);
    idle();

    // identifier ignores array contents
    prog(17'd0, 8'h00, 1'b0, 1'b0);
    prog(17'd1, 8'h00, 1'b0, 1'b0);
    rd(17'd0, 1'b0, 1'b1, 8'h20, "R8 manufacturer id");
    rd(17'd1, 1'b0, 1'b1, 8'h05, "R8 device id");
    rd(17'd0, 1'b0, 1'b0, 8'h00, "R8 array under id");

    // bulk erase, and its priority over a write
    @(negedge clk);
    erase_i = 1'b1;
    @(negedge clk);
    erase_i = 1'b0;
    rd(17'd5, 1'b0, 1'b0, 8'hFF, "R9 erase word5");
    rd(17'd12, 1'b0, 1'b0, 8'hFF, "R9 erase word12");
    prog(17'd30, 8'h00, 1'b0, 1'b1);
    rd(17'd30, 1'b0, 1'b0, 8'hFF, "R9 erase beats write");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule